// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time

This block is the synchronous control core that decides, every clock cycle, which of the four switches in a full H-bridge may conduct. The bridge has two independent legs. Each leg has one low-side switch and one high-side switch, and each leg has its own low-side and high-side request. The four gate-enable outputs feed external level shifters and drivers. Those drivers, and the analog undervoltage detectors, are outside this block. Their results arrive here as logic flags: one global disable, one supply-undervoltage flag and one bootstrap-undervoltage flag per leg.

Within a leg, a low-side request always takes priority over a high-side request, so the two switches of a leg can never be enabled together. A turn-on waits for a programmable number of dead cycles. A turn-off takes effect with no extra wait. If the high-side request is held high permanently, the low-side request alone drives the leg as a complementary pair, with a dead gap at every change.

When the disable is released, each low-side switch is pulsed on for a programmable number of cycles. This recharges the bootstrap capacitors before any high-side switch is allowed to turn on. Requests shorter than a programmable minimum width are discarded. Every flag and request passes through a two-flop synchronizer. The three timing values are quasi-static configuration inputs and are not synchronized.

Top module: `hbridge_gate_ctrl`

## Requirements

In these requirements, M is `min_pulse_i` (taken as at least 1), D is `dead_cycles_i` and R is `refresh_cycles_i`. Edges are rising clock edges, counted from 1 at the first edge that samples an input change. Leg j uses bit j of every per-leg bus.

- R1: The two legs act independently. Each leg applies the rules below only to its own request bits, its own bootstrap flag and its own output bits.
- R2: While `disable_i` is high, all four gate outputs are low. After `disable_i` rises, the outputs are low from edge 2 onward.
- R3: While `supply_uv_i` is high, all four gate outputs are low. After `supply_uv_i` rises, the outputs are low from edge 2 onward. Releasing `supply_uv_i` produces no refresh pulse.
- R4: In steady state with no disable and no undervoltage, a high low-side request gives low gate 1 and high gate 0 for that leg, whatever the high-side request is.
- R5: In steady state with the low-side request low, a high-side request gives high gate 1 and low gate 0. With both requests low, both gates are 0.
- R6: A high bootstrap-undervoltage flag on a leg holds that leg's high gate low. The leg's low gate still follows its low-side request.
- R7: A gate that is allowed to turn on rises at edge M+D+3 after its request changes.
- R8: A gate turns off at edge M+2 after its request falls, for any value of D.
- R9: With the high-side request tied high, toggling the low-side request makes the gate being released fall at edge M+2 and the other gate rise at edge M+D+3.
- R10: When `disable_i` falls, no supply undervoltage is present and R is nonzero, each low gate rises at edge D+4 and stays high for exactly R cycles. During that time the high gates stay low. A pending high gate rises at edge 2D+R+5. When R is 0 there is no pulse, and a pending high gate rises at edge D+3.
- R11: A rising `disable_i` or `supply_uv_i` during a refresh pulse ends the pulse, and the low gate is low from edge 2 onward. The next release of `disable_i` produces a complete pulse of R cycles.
- R12: A request level held for fewer than M synchronized cycles has no effect on the gates. A level held for exactly M cycles is accepted.
- R13: The low gate and the high gate of one leg are never high in the same cycle. Whichever gate of a leg rises, the other gate was low in the previous cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disable_i | input | 1 | Global disable; high forces all gates low |
| supply_uv_i | input | 1 | Supply undervoltage flag; high forces all gates low |
| boot_uv_i | input | LEGS (2) | Per-leg bootstrap undervoltage flag; blocks that leg's high gate |
| lo_req_i | input | LEGS (2) | Per-leg low-side request |
| hi_req_i | input | LEGS (2) | Per-leg high-side request |
| dead_cycles_i | input | DEAD_W (8) | Turn-on dead time in cycles |
| refresh_cycles_i | input | REFRESH_W (8) | Refresh pulse width in cycles; 0 disables the pulse |
| min_pulse_i | input | MINPW_W (4) | Minimum accepted request width in cycles |
| lo_gate_o | output | LEGS (2) | Low-side gate enables |
| hi_gate_o | output | LEGS (2) | High-side gate enables |

## Verification

The assertions check, on every cycle, the properties that need no timing count. These are:

- the two gates of a leg are never both on;
- a synchronized disable, supply undervoltage or bootstrap undervoltage keeps the affected gates off;
- a qualified low-side request keeps the high gate off;
- no high gate is on during a refresh pulse;
- whenever a gate rises, the opposite gate of its leg was off in the previous cycle.

The exact edge at which a gate turns on or off for a given dead time and minimum width can only be shown by the bench scenarios. The same holds for the width and start of the refresh pulse, its abort and full restart, the late start of the high side, and the rejection of short requests. The bench measures each of these against arithmetic expectations, after a near-exhaustive sweep of all request and flag combinations in steady state.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Refresh sequencer state of one leg.
  typedef enum logic {
    RF_IDLE   = 1'b0,
    RF_ACTIVE = 1'b1
  } refresh_state_e;

  // Qualified requests of one leg.
  typedef struct packed {
    logic lo;
    logic hi;
  } leg_req_t;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/hbg_min_pulse.sv
module hbg_min_pulse #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  input  logic [CW-1:0] min_i,
  output logic          lvl_o
);

  localparam int XW = CW + 1;

  logic          lvl_q;
  logic          lvl_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic [XW-1:0] run_len;

  assign run_len = {1'b0, cnt_q} + XW'(1);

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (lvl_i == lvl_q) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (run_len >= {1'b0, min_i}) begin
      lvl_d  = lvl_i;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;

  // R12: the qualified level only moves toward a differing input level
  p_filter_moves_toward_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(lvl_i) != $past(lvl_q)));

endmodule

// File: rtl/hbg_ontimer.sv
module hbg_ontimer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tgt_i,
  input  logic [DW-1:0] dead_i,
  output logic          gate_o
);

  logic          tgt_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          cnt_en;
  logic          tgt_chg;

  assign tgt_chg = tgt_i ^ tgt_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (tgt_chg) begin
      cnt_d  = dead_i;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // Turn-off follows the target at once; turn-on waits for the count.
  assign gate_o = tgt_i & tgt_q & (cnt_q == '0);

  // R7: a gate only rises after its target was already held
  p_rise_needs_held_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(tgt_i));

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg import hbg_pkg::*; #(
  parameter int DW = 8,
  parameter int RW = 8,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_req_i,
  input  logic          hi_req_i,
  input  logic          dis_i,
  input  logic          dis_rel_i,
  input  logic          sup_uv_i,
  input  logic          boot_uv_i,
  input  logic [MW-1:0] min_i,
  input  logic [DW-1:0] dead_i,
  input  logic [RW-1:0] refresh_i,
  output logic          lo_gate_o,
  output logic          hi_gate_o
);

  localparam int RXW = RW + 1;

  leg_req_t       req_f;
  refresh_state_e rf_q;
  refresh_state_e rf_d;
  logic [RW-1:0]  rc_q;
  logic [RW-1:0]  rc_d;
  logic           rc_en;
  logic           rf_start;
  logic           rf_active;
  logic           blocked;
  logic           lo_tgt;
  logic           hi_tgt;
  logic           lo_gate;
  logic           hi_gate;
  logic [RXW-1:0] rc_next;

  hbg_min_pulse #(.CW(MW)) u_lo_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lo_req_i),
    .min_i (min_i),
    .lvl_o (req_f.lo)
  );

  hbg_min_pulse #(.CW(MW)) u_hi_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (hi_req_i),
    .min_i (min_i),
    .lvl_o (req_f.hi)
  );

  assign blocked   = dis_i | sup_uv_i;
  assign rf_start  = dis_rel_i & ~sup_uv_i & (refresh_i != '0);
  assign rf_active = (rf_q == RF_ACTIVE);
  assign rc_next   = {1'b0, rc_q} + RXW'(1);

  // Refresh sequencer: counts cycles in which the low gate is really on.
  always_comb begin
    rf_d  = rf_q;
    rc_d  = rc_q;
    rc_en = 1'b0;
    unique case (rf_q)
      RF_IDLE: begin
        if (rf_start) begin
          rf_d  = RF_ACTIVE;
          rc_d  = '0;
          rc_en = 1'b1;
        end
      end
      RF_ACTIVE: begin
        if (blocked) begin
          rf_d  = RF_IDLE;
          rc_d  = '0;
          rc_en = 1'b1;
        end else if (lo_gate) begin
          rc_en = 1'b1;
          if (rc_next >= {1'b0, refresh_i}) begin
            rf_d = RF_IDLE;
            rc_d = '0;
          end else begin
            rc_d = rc_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q <= RF_IDLE;
      rc_q <= '0;
    end else begin
      rf_q <= rf_d;
      if (rc_en) rc_q <= rc_d;
    end
  end

  // Target decode: low side wins, refresh forces low side, blocks high side.
  assign lo_tgt = ~blocked & (req_f.lo | rf_active);
  assign hi_tgt = ~blocked & ~boot_uv_i & req_f.hi & ~req_f.lo & ~rf_active & ~rf_start;

  hbg_ontimer #(.DW(DW)) u_lo_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt_i  (lo_tgt),
    .dead_i (dead_i),
    .gate_o (lo_gate)
  );

  hbg_ontimer #(.DW(DW)) u_hi_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt_i  (hi_tgt),
    .dead_i (dead_i),
    .gate_o (hi_gate)
  );

  assign lo_gate_o = lo_gate;
  assign hi_gate_o = hi_gate;

  // R13: never both switches of the leg
  p_leg_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_gate && hi_gate));
  // R13: each rise follows a cycle with the opposite gate off
  p_hi_rise_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> !$past(lo_gate));
  p_lo_rise_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate) |-> !$past(hi_gate));
  // R2: synchronized disable holds both gates off
  p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |-> (!lo_gate && !hi_gate));
  // R3: synchronized supply undervoltage holds both gates off
  p_supply_uv_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sup_uv_i |-> (!lo_gate && !hi_gate));
  // R6: bootstrap undervoltage holds the high gate off
  p_boot_uv_hi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_uv_i |-> !hi_gate);
  // R4: a qualified low-side request keeps the high gate off
  p_low_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_f.lo |-> !hi_gate);
  // R10: no high gate during a refresh pulse
  p_refresh_hi_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_active |-> !hi_gate);

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl #(
  parameter int LEGS      = 2,
  parameter int DEAD_W    = 8,
  parameter int REFRESH_W = 8,
  parameter int MINPW_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disable_i,
  input  logic                 supply_uv_i,
  input  logic [LEGS-1:0]      boot_uv_i,
  input  logic [LEGS-1:0]      lo_req_i,
  input  logic [LEGS-1:0]      hi_req_i,
  input  logic [DEAD_W-1:0]    dead_cycles_i,
  input  logic [REFRESH_W-1:0] refresh_cycles_i,
  input  logic [MINPW_W-1:0]   min_pulse_i,
  output logic [LEGS-1:0]      lo_gate_o,
  output logic [LEGS-1:0]      hi_gate_o
);

  localparam int SW = 2 + 3 * LEGS;

  logic [SW-1:0]   sync_in;
  logic [SW-1:0]   sync_out;
  logic [LEGS-1:0] lo_s;
  logic [LEGS-1:0] hi_s;
  logic [LEGS-1:0] buv_s;
  logic            dis_s;
  logic            uv_s;
  logic            dis_prev_q;
  logic            dis_rel;

  assign sync_in = {supply_uv_i, disable_i, boot_uv_i, hi_req_i, lo_req_i};

  hbg_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );

  assign {uv_s, dis_s, buv_s, hi_s, lo_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_prev_q <= 1'b0;
    else        dis_prev_q <= dis_s;
  end

  assign dis_rel = dis_prev_q & ~dis_s;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hbg_leg #(
      .DW (DEAD_W),
      .RW (REFRESH_W),
      .MW (MINPW_W)
    ) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .lo_req_i  (lo_s[g]),
      .hi_req_i  (hi_s[g]),
      .dis_i     (dis_s),
      .dis_rel_i (dis_rel),
      .sup_uv_i  (uv_s),
      .boot_uv_i (buv_s[g]),
      .min_i     (min_pulse_i),
      .dead_i    (dead_cycles_i),
      .refresh_i (refresh_cycles_i),
      .lo_gate_o (lo_gate_o[g]),
      .hi_gate_o (hi_gate_o[g])
    );
  end

endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dis = 1'b0;
  logic       uv = 1'b0;
  logic [1:0] buv = '0;
  logic [1:0] li = '0;
  logic [1:0] hi = '0;
  logic [7:0] dead = '0;
  logic [7:0] refr = '0;
  logic [3:0] minp = 4'd1;
  logic [1:0] lo_g;
  logic [1:0] hi_g;

  int  cyc = 0;
  int  t0 = 0;
  int  checks = 0;
  int  fails = 0;
  int  overlaps = 0;
  bit  done = 0;
  int  mm, dd, rr;

  hbridge_gate_ctrl u_hbridge_gate_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .disable_i        (dis),
    .supply_uv_i      (uv),
    .boot_uv_i        (buv),
    .lo_req_i         (li),
    .hi_req_i         (hi),
    .dead_cycles_i    (dead),
    .refresh_cycles_i (refr),
    .min_pulse_i      (minp),
    .lo_gate_o        (lo_g),
    .hi_gate_o        (hi_g)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && ((lo_g & hi_g) != 2'b00)) overlaps++;

  function automatic logic getout(int sel);
    case (sel)
      0: return lo_g[0];
      1: return hi_g[0];
      2: return lo_g[1];
      default: return hi_g[1];
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(int m, int d, int r);
    mm = m; dd = d; rr = r;
    minp = 4'(m); dead = 8'(d); refr = 8'(r);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Edge number (counted from t0) at which output sel first equals val; -1 if never.
  task automatic wait_for(int sel, logic val, int maxk, output int e);
    e = -1;
    for (int i = 0; i < maxk; i++) begin
      @(negedge clk);
      if (getout(sel) == val) begin
        e = cyc - t0;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e;
    cfg(1, 2, 3);
    settle(4);
    check("reset lo gates", lo_g, 0);
    check("reset hi gates", hi_g, 0);
    @(negedge clk) rst_n = 1'b1;
    settle(10);

    // Steady-state sweep over every request and flag combination.
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      li = v[1:0]; hi = v[3:2]; buv = v[5:4]; dis = v[6]; uv = v[7];
      settle(20);
      begin
        logic [1:0] elo, ehi;
        string tag;
        for (int j = 0; j < 2; j++) begin
          elo[j] = !dis && !uv && li[j];
          ehi[j] = !dis && !uv && !buv[j] && hi[j] && !li[j];
        end
        tag = dis ? "R2 sweep" : (uv ? "R3 sweep" : "R1/R4/R5/R6 sweep");
        check(tag, {hi_g, lo_g}, {ehi, elo});
      end
    end
    @(negedge clk); li = 0; hi = 0; buv = 0; dis = 0; uv = 0;
    settle(20);

    // R7/R8 turn-on and turn-off edges.
    cfg(1, 5, 3); settle(5);
    @(negedge clk); li[0] = 1'b1; t0 = cyc;
    wait_for(0, 1'b1, 40, e); check("R7 lo on edge", e, mm + dd + 3);
    settle(5);
    @(negedge clk); li[0] = 1'b0; t0 = cyc;
    wait_for(0, 1'b0, 40, e); check("R8 lo off edge", e, mm + 2);
    settle(10);
    cfg(1, 0, 3); settle(5);
    @(negedge clk); hi[1] = 1'b1; t0 = cyc;
    wait_for(3, 1'b1, 40, e); check("R7 hi on edge zero dead", e, mm + dd + 3);
    cfg(2, 9, 3); settle(5);
    @(negedge clk); hi[1] = 1'b0; t0 = cyc;
    wait_for(3, 1'b0, 40, e); check("R8 hi off edge long dead", e, mm + 2);
    settle(20);
    @(negedge clk); hi[1] = 1'b1; t0 = cyc;
    wait_for(3, 1'b1, 40, e); check("R7 hi on edge long dead", e, mm + dd + 3);
    @(negedge clk); hi[1] = 1'b0;
    settle(20);

    // R9 complementary mode with the high request tied high.
    cfg(1, 3, 3);
    @(negedge clk); hi[0] = 1'b1; li[0] = 1'b1;
    settle(30);
    @(negedge clk); li[0] = 1'b0; t0 = cyc;
    wait_for(0, 1'b0, 40, e); check("R9 lo release edge", e, mm + 2);
    wait_for(1, 1'b1, 40, e); check("R9 hi take edge", e, mm + dd + 3);
    settle(5);
    @(negedge clk); li[0] = 1'b1; t0 = cyc;
    wait_for(1, 1'b0, 40, e); check("R9 hi release edge", e, mm + 2);
    wait_for(0, 1'b1, 40, e); check("R9 lo take edge", e, mm + dd + 3);
    @(negedge clk); li[0] = 1'b0; hi[0] = 1'b0;
    settle(20);

    // R10 refresh pulse after disable release.
    cfg(1, 2, 6);
    @(negedge clk); hi = 2'b11; dis = 1'b1;
    settle(30);
    @(negedge clk); dis = 1'b0; t0 = cyc;
    wait_for(0, 1'b1, 40, e); check("R10 refresh start edge", e, dd + 4);
    check("R10 leg1 refresh active", lo_g[1], 1);
    check("R10 hi held during refresh", hi_g, 0);
    wait_for(0, 1'b0, 40, e); check("R10 refresh end edge", e, dd + 4 + rr);
    wait_for(1, 1'b1, 40, e); check("R10 hi late start edge", e, 2 * dd + rr + 5);
    settle(3);
    check("R10 leg1 hi on after refresh", hi_g[1], 1);
    cfg(1, 2, 0);
    @(negedge clk); dis = 1'b1;
    settle(30);
    @(negedge clk); dis = 1'b0; t0 = cyc;
    wait_for(1, 1'b1, 40, e); check("R10 no refresh hi edge", e, dd + 3);
    @(negedge clk); hi = 2'b00;
    settle(20);

    // R11 abort by disable, then full restart.
    cfg(1, 1, 8);
    @(negedge clk); dis = 1'b1;
    settle(30);
    @(negedge clk); dis = 1'b0; t0 = cyc;
    wait_for(0, 1'b1, 40, e); check("R11 first pulse start", e, dd + 4);
    settle(3);
    @(negedge clk); dis = 1'b1; t0 = cyc;
    wait_for(0, 1'b0, 40, e); check("R11 R2 abort by disable edge", e, 2);
    settle(10);
    @(negedge clk); dis = 1'b0; t0 = cyc;
    wait_for(0, 1'b1, 40, e); check("R11 restart start", e, dd + 4);
    wait_for(0, 1'b0, 40, e); check("R11 restart full width", e, dd + 4 + rr);
    settle(10);

    // R11/R3 abort by supply undervoltage; release gives no pulse.
    @(negedge clk); dis = 1'b1;
    settle(30);
    @(negedge clk); dis = 1'b0;
    settle(8);
    check("R11 pulse on before undervoltage", lo_g[0], 1);
    @(negedge clk); uv = 1'b1; t0 = cyc;
    wait_for(0, 1'b0, 40, e); check("R11 R3 abort by undervoltage edge", e, 2);
    settle(10);
    @(negedge clk); uv = 1'b0; hi[0] = 1'b1; t0 = cyc;
    wait_for(0, 1'b1, 20, e); check("R3 no pulse on undervoltage release", e, -1);
    check("R3 hi resumes after undervoltage", hi_g[0], 1);
    @(negedge clk); hi[0] = 1'b0;
    settle(20);

    // R12 minimum request width.
    cfg(4, 0, 0);
    @(negedge clk); li[1] = 1'b1; t0 = cyc;
    settle(3);
    li[1] = 1'b0;
    wait_for(2, 1'b1, 20, e); check("R12 short request ignored", e, -1);
    @(negedge clk); li[1] = 1'b1; t0 = cyc;
    settle(4);
    li[1] = 1'b0;
    wait_for(2, 1'b1, 20, e); check("R12 exact width accepted", e, mm + dd + 3);
    settle(20);

    check("R13 no same-leg overlap seen", overlaps, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule